// File: doc/BRIEF.md
# PWM Output Fault Gate

This block sits between a bank of PWM generators and the output pins. It forces chosen channels to their inactive level when something asks for it. There are three disable sources: an asynchronous external fault input and two software disable bits. Each source has its own channel map, so each source acts only on the channels it selects. The inactive level of a channel follows that channel's polarity. A positive-polarity channel is driven low. A negative-polarity channel is driven high. The generators upstream keep counting while their outputs are forced, so this block never stops or resets them.

A fault sets a flag, and the flag can raise an interrupt. The release of a forced channel can work in one of two ways:
- **Automatic:** the channel follows the synchronized fault input.
- **Manual:** the channel stays forced until the fault input has gone low and software has also cleared the flag.

In both modes a channel is driven again only at a PWM period boundary. An `period_end` strobe from the generators marks that boundary, so no partial pulse reaches the pin.

Top module: `pwm_fault_gate`

## Requirements
- R1: While reset is low, and right after it is released, `fault_flag` and `irq` are 0 and no channel is held forced.
- R2: A channel with no active disable request drives its PWM input to the pin. If `pol_pos`=1 the pin carries the input unchanged; if `pol_pos`=0 it carries the inverted input.
- R3: `fault_pin` passes through a two-stage synchronizer. It forces every channel with a 1 in `fault_map` from the second rising edge after it is sampled high. The forced level is 0 when `pol_pos`=1 and 1 when `pol_pos`=0, whatever the PWM input is.
- R4: When `dis0`=1, every channel with a 1 in `dis0_map` is forced to its inactive level in the same cycle. When `dis1`=1, every channel with a 1 in `dis1_map` is forced in the same cycle.
- R5: A channel that is not selected by any active source keeps following R2 while other channels are forced.
- R6: `fault_flag` is set on the edge after the synchronized fault is high. A `flag_clr` pulse clears it only while the synchronized fault is low; if both happen in the same cycle, setting wins.
- R7: `irq` equals `fault_flag` AND `irq_en`.
- R8: Once a channel has been forced, it stays forced after its request drops, and is released on the first rising edge at which `period_end`=1 and no request is active.
- R9: With `manual_mode`=1, a set `fault_flag` keeps every channel selected by `fault_map` forced, even after `fault_pin` returns low. Release then follows R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| fault_pin | input | 1 | External fault input, asynchronous, active high |
| dis0 | input | 1 | Software disable source 0 |
| dis1 | input | 1 | Software disable source 1 |
| fault_map | input | NCH | Channels affected by the fault input |
| dis0_map | input | NCH | Channels affected by dis0 |
| dis1_map | input | NCH | Channels affected by dis1 |
| manual_mode | input | 1 | 1: latched release through flag clear; 0: automatic release |
| flag_clr | input | 1 | One-cycle strobe that clears the fault flag |
| irq_en | input | 1 | Fault interrupt enable |
| period_end | input | 1 | Last cycle of a PWM period |
| pwm_in | input | NCH | Raw active-high PWM signals from the generators |
| pol_pos | input | NCH | Per-channel polarity, 1 = positive |
| pwm_out | output | NCH | Gated, polarity-mapped pin drive |
| fault_flag | output | 1 | Latched fault indication |
| irq | output | 1 | Fault interrupt request |

## Verification
The hardest situation to reach is a manual-mode release. It needs a fault that has passed the synchronizer and has since gone low. Software must then clear the flag, and the next period boundary must come after that. Each of these steps can happen in the wrong order. The stimulus walks through that sequence on purpose:
- a clear pulse while the fault is still high, which must be ignored;
- a later clear pulse after the fault has gone low;
- a wait for the period strobe, which arrives every fourth cycle.

A randomized phase then mixes all sources against a cycle-by-cycle model, so that requests drop both in the middle of a period and at its boundary.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;

  typedef enum logic {
    REL_AUTO   = 1'b0,
    REL_MANUAL = 1'b1
  } rel_mode_e;

  // Pin level for a channel given the raw active-high value and polarity.
  function automatic logic pin_level(input logic active, input logic pos);
    return pos ? active : ~active;
  endfunction

endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;
  logic [STAGES-1:0] shreg_nxt;

  always_comb begin
    shreg_nxt = {shreg[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= shreg_nxt;
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/fault_latch.sv
module fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_s,
  input  logic flag_clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_nxt;
  logic flag_en;

  always_comb begin
    flag_en  = fault_s | flag_clr;
    flag_nxt = flag;
    if (fault_s)       flag_nxt = 1'b1;
    else if (flag_clr) flag_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (flag_en) flag <= flag_nxt;
  end

  assign irq = flag & irq_en;
endmodule

// File: rtl/chan_gate.sv
module chan_gate
  import pwm_fault_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic period_end,
  input  logic pwm_raw,
  input  logic pol_pos,
  output logic pwm_pin,
  output logic blocked
);
  logic blk_nxt;
  logic blk_en;
  logic forced;

  always_comb begin
    blk_en  = req | period_end;
    blk_nxt = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blocked <= 1'b0;
    else if (blk_en) blocked <= blk_nxt;
  end

  always_comb begin
    forced  = req | blocked;
    pwm_pin = pin_level(forced ? 1'b0 : pwm_raw, pol_pos);
  end
endmodule

// File: rtl/pwm_fault_gate.sv
module pwm_fault_gate
  import pwm_fault_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int SYNC_STGS = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fault_pin,
  input  logic           dis0,
  input  logic           dis1,
  input  logic [NCH-1:0] fault_map,
  input  logic [NCH-1:0] dis0_map,
  input  logic [NCH-1:0] dis1_map,
  input  logic           manual_mode,
  input  logic           flag_clr,
  input  logic           irq_en,
  input  logic           period_end,
  input  logic [NCH-1:0] pwm_in,
  input  logic [NCH-1:0] pol_pos,
  output logic [NCH-1:0] pwm_out,
  output logic           fault_flag,
  output logic           irq
);
  logic           fault_s;
  logic           fault_req;
  rel_mode_e      rel_mode;
  logic [NCH-1:0] chan_req;
  logic [NCH-1:0] chan_blk;

  fault_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (fault_pin),
    .q     (fault_s)
  );

  fault_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault_s  (fault_s),
    .flag_clr (flag_clr),
    .irq_en   (irq_en),
    .flag     (fault_flag),
    .irq      (irq)
  );

  always_comb begin
    rel_mode  = rel_mode_e'(manual_mode);
    fault_req = fault_s | ((rel_mode == REL_MANUAL) & fault_flag);
    chan_req  = ({NCH{fault_req}} & fault_map)
              | ({NCH{dis0}} & dis0_map)
              | ({NCH{dis1}} & dis1_map);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (chan_req[g]),
      .period_end (period_end),
      .pwm_raw    (pwm_in[g]),
      .pol_pos    (pol_pos[g]),
      .pwm_pin    (pwm_out[g]),
      .blocked    (chan_blk[g])
    );
  end
endmodule

// File: rtl/pwm_fault_gate_chk.sv
module pwm_fault_gate_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fault_s,
  input logic           fault_flag,
  input logic           flag_clr,
  input logic           irq,
  input logic           manual_mode,
  input logic           dis0,
  input logic           dis1,
  input logic [NCH-1:0] fault_map,
  input logic [NCH-1:0] dis0_map,
  input logic [NCH-1:0] dis1_map,
  input logic [NCH-1:0] pol_pos,
  input logic           period_end,
  input logic [NCH-1:0] chan_blk,
  input logic [NCH-1:0] pwm_out
);
  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_s |=> fault_flag);

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag && !flag_clr |=> fault_flag);

  // R7
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> fault_flag);

  for (genvar g = 0; g < NCH; g++) begin : g_ach
    // R3
    fault_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_s && fault_map[g] |-> pwm_out[g] == ~pol_pos[g]);

    // R4
    dis_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dis0 && dis0_map[g]) || (dis1 && dis1_map[g]) |-> pwm_out[g] == ~pol_pos[g]);

    // R9
    manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      manual_mode && fault_flag && fault_map[g] |-> pwm_out[g] == ~pol_pos[g]);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_blk[g]) |-> $past(period_end));
  end
endmodule

bind pwm_fault_gate pwm_fault_gate_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fault_s     (fault_s),
  .fault_flag  (fault_flag),
  .flag_clr    (flag_clr),
  .irq         (irq),
  .manual_mode (manual_mode),
  .dis0        (dis0),
  .dis1        (dis1),
  .fault_map   (fault_map),
  .dis0_map    (dis0_map),
  .dis1_map    (dis1_map),
  .pol_pos     (pol_pos),
  .period_end  (period_end),
  .chan_blk    (chan_blk),
  .pwm_out     (pwm_out)
);

// File: tb/sim_pwm_fault_gate.sv
`timescale 1ns/1ps
module sim_pwm_fault_gate;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           fault_pin, dis0, dis1, manual_mode, flag_clr, irq_en, period_end;
  logic [NCH-1:0] fault_map, dis0_map, dis1_map, pwm_in, pol_pos;
  logic [NCH-1:0] pwm_out;
  logic           fault_flag, irq;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";
  int    pcnt    = 0;

  always #2 clk = ~clk;

  pwm_fault_gate #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .fault_pin(fault_pin), .dis0(dis0), .dis1(dis1),
    .fault_map(fault_map), .dis0_map(dis0_map), .dis1_map(dis1_map),
    .manual_mode(manual_mode), .flag_clr(flag_clr), .irq_en(irq_en),
    .period_end(period_end), .pwm_in(pwm_in), .pol_pos(pol_pos),
    .pwm_out(pwm_out), .fault_flag(fault_flag), .irq(irq)
  );

  // Behavioural reference: synchronizer as a queue, a flag and hold bits.
  bit sync_q[$];
  bit m_flag;
  bit m_hold[NCH];

  function automatic bit m_sync_out();
    return sync_q[0];
  endfunction

  function automatic bit m_request(int c);
    bit f;
    f = m_sync_out() || (manual_mode && m_flag);
    return (f && fault_map[c]) || (dis0 && dis0_map[c]) || (dis1 && dis1_map[c]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q = '{0, 0};
      m_flag = 0;
      foreach (m_hold[c]) m_hold[c] = 0;
    end else begin
      bit nreq[NCH];
      bit s_now;
      s_now = m_sync_out();
      for (int c = 0; c < NCH; c++) nreq[c] = m_request(c);
      if (s_now) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      for (int c = 0; c < NCH; c++) begin
        if (nreq[c]) m_hold[c] = 1;
        else if (period_end) m_hold[c] = 0;
      end
      void'(sync_q.pop_front());
      sync_q.push_back(fault_pin);
    end
  end

  task automatic compare();
    logic [NCH-1:0] exp_out;
    bit exp_irq;
    for (int c = 0; c < NCH; c++) begin
      if (m_hold[c] || m_request(c)) exp_out[c] = ~pol_pos[c];
      else exp_out[c] = pol_pos[c] ? pwm_in[c] : ~pwm_in[c];
    end
    exp_irq = m_flag && irq_en;
    n_tests++;
    if (pwm_out !== exp_out) begin
      n_fail++;
      $display("FAIL %s pwm_out actual=%b expected=%b t=%0t", cur_req, pwm_out, exp_out, $time);
    end
    n_tests++;
    if (fault_flag !== m_flag) begin
      n_fail++;
      $display("FAIL %s fault_flag actual=%b expected=%b t=%0t", cur_req, fault_flag, m_flag, $time);
    end
    n_tests++;
    if (irq !== exp_irq) begin
      n_fail++;
      $display("FAIL R7 irq (%s) actual=%b expected=%b t=%0t", cur_req, irq, exp_irq, $time);
    end
  endtask

  // One clock: sample after the edge, then advance the period strobe.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
    flag_clr   = 1'b0;
    pcnt       = (pcnt + 1) % 4;
    period_end = (pcnt == 3);
    pwm_in     = NCH'($urandom);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin : watchdog
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fault_pin = 0; dis0 = 0; dis1 = 0; manual_mode = 0;
    flag_clr = 0; irq_en = 1; period_end = 0;
    fault_map = '0; dis0_map = '0; dis1_map = '0; pwm_in = '0; pol_pos = 4'b0101;
    // R1: state during reset
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    cur_req = "R1"; ticks(2);

    // R2: plain pass-through under two polarity patterns
    cur_req = "R2"; ticks(8);
    pol_pos = 4'b1010; ticks(8);

    // R4 and R5: software disables with separate maps
    cur_req = "R4"; dis0_map = 4'b0011; dis1_map = 4'b1000;
    dis0 = 1; ticks(3);
    dis1 = 1; ticks(3);
    dis0 = 0; dis1 = 0;
    cur_req = "R8"; ticks(8);

    // R3, R5, R6, R7 in automatic mode
    cur_req = "R3"; fault_map = 4'b0110; fault_pin = 1; ticks(6);
    cur_req = "R6"; flag_clr = 1; ticks(1);       // ignored while fault high
    fault_pin = 0; cur_req = "R8"; ticks(6);
    cur_req = "R6"; flag_clr = 1; ticks(3);
    cur_req = "R7"; irq_en = 0; fault_pin = 1; ticks(4);
    irq_en = 1; ticks(2); fault_pin = 0; ticks(3);
    flag_clr = 1; ticks(4);
    cur_req = "R5"; ticks(4);

    // R9: manual release needs clear and a period boundary
    cur_req = "R9"; manual_mode = 1; fault_pin = 1; ticks(3);
    fault_pin = 0; ticks(9);
    flag_clr = 1; ticks(1);
    cur_req = "R8"; ticks(8);

    // Mixed pseudo-random phase across all sources (R2..R9)
    cur_req = "R8";
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 7) == 0) fault_pin = ~fault_pin;
      if ($urandom_range(0, 9) == 0) dis0 = ~dis0;
      if ($urandom_range(0, 9) == 0) dis1 = ~dis1;
      if ($urandom_range(0, 19) == 0) manual_mode = ~manual_mode;
      if ($urandom_range(0, 5) == 0) flag_clr = 1;
      if ($urandom_range(0, 31) == 0) begin
        fault_map = NCH'($urandom); dis0_map = NCH'($urandom);
        dis1_map = NCH'($urandom); pol_pos = NCH'($urandom);
      end
      @(posedge clk); @(negedge clk); compare();
      flag_clr = 0;
      pcnt = (pcnt + 1) % 4; period_end = (pcnt == 3);
      pwm_in = NCH'($urandom);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule